// File: doc/BRIEF.md
# DMA Channel Trigger Burst Sequencer

This block is the per-channel control section of a DMA engine. It decides when its channel may move data, how many beats each hardware trigger grants, and which source and destination addresses each beat uses. A start pulse loads a transfer count and the two start addresses. From then on the block raises a request towards a channel arbiter whenever a grant is outstanding. It counts the beats that the bus side reports as complete and flags completion when the count is used up.

A 14-bit configuration word controls the channel. A 4-bit exponent sets the burst length to a power of two between 1 and 1024. That length is also the window for address wrapping: when wrap is on for a side, that side's address returns to its start value after every full burst, so each burst touches the same range. The hardware trigger can be edge or level sensed, with either polarity. Each trigger grants either one beat or a whole burst. A separate enable lets the channel follow a peripheral request line or ignore it, which is the case for memory-to-memory moves. A 3-bit priority field is passed through to the arbiter.

Configuration word layout (bit positions): [0] follow peripheral request, [1] hardware trigger enable, [2] level sensing (0 = edge), [3] trigger active high / rising (0 = active low / falling), [4] whole burst per trigger (0 = one beat), [5] source wrap, [6] destination wrap, [10:7] burst exponent, [13:11] priority (0 highest, 7 lowest).

Top module: `dma_burst_seq`

## Requirements
- R1: The burst length is 2 to the power of the exponent in bits [10:7]. Exponents 0 to 10 are accepted, giving lengths 1 to 1024. A start pulse with an exponent above 10 sets `cfg_err` and does not start the channel.
- R2: A start pulse whose `xfer_count` is zero, or is not a whole multiple of the burst length, sets `cfg_err` and leaves `ch_req` low with no beats taken. A start pulse with a valid shape clears `cfg_err` and loads the count and both start addresses.
- R3: With the hardware trigger enable (bit 1) clear, an active channel requests immediately after start and keeps requesting until all beats are done.
- R4: With the hardware trigger enable set, no request is raised without a trigger. Each trigger grants one beat when bit 4 is 0, and a full burst when bit 4 is 1. The request drops as soon as the granted beats are consumed.
- R5: In edge mode (bit 2 = 0) a rising edge triggers when bit 3 is 1, and a falling edge when bit 3 is 0. Any number of edges that arrive while a grant is still open are remembered as a single extra grant, which is served after the current one ends.
- R6: In level mode (bit 2 = 1) grants are reissued for as long as the trigger stays at its active level (high when bit 3 is 1, low when 0). The inactive level grants nothing.
- R7: With bit 0 set, `ch_req` is raised only while `periph_req` is high. With bit 0 clear, `periph_req` has no effect.
- R8: A beat completes when `beat_done` is high while `ch_req` is high. Each side's address then advances by its step, unless that side wraps. `beat_done` while `ch_req` is low changes no address.
- R9: With source wrap (bit 5) set, the source address returns to its start value after the last beat of every burst. Destination wrap (bit 6) does the same for the destination. The two controls are independent.
- R10: The remaining count drops by one per completed beat. After the last beat `xfer_done` goes high and `ch_req` stays low until the next start. After reset `ch_req`, `xfer_done` and `cfg_err` are low.
- R11: `ch_prio` always equals configuration bits [13:11].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 14 | Channel configuration word |
| start | input | 1 | Pulse that loads the count and addresses and begins a transfer |
| xfer_count | input | CNT_W | Total number of beats |
| src_base | input | AW | Source start address |
| dst_base | input | AW | Destination start address |
| src_step | input | AW | Source address increment per beat |
| dst_step | input | AW | Destination address increment per beat |
| periph_req | input | 1 | Raw peripheral request |
| hw_trig | input | 1 | Raw hardware trigger |
| beat_done | input | 1 | Bus side reports the current beat complete |
| ch_req | output | 1 | Request to the channel arbiter |
| ch_prio | output | 3 | Channel priority level |
| src_addr | output | AW | Source address of the current beat |
| dst_addr | output | AW | Destination address of the current beat |
| xfer_done | output | 1 | Whole transfer finished |
| cfg_err | output | 1 | Last start pulse had an invalid shape |

## Verification
The assertions check on every cycle that a completed beat always moves an address by its step or back to its start, and that the grant counter falls by exactly one per beat. They also check that a beat happens only while a grant is open, that an edge event lasts one cycle, and that a rejected start or the last beat leaves the request low. Several behaviours are visible only across whole scenarios, so only the bench can show them. These are how many beats a trigger grants, that edges arriving during a burst fold into one extra grant, that level sensing repeats while the trigger is held, that the peripheral request gates the channel, and the full address sequence with and without wrap.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  localparam int unsigned MAX_POW = 10;
  localparam int unsigned LEN_W   = MAX_POW + 1;

  typedef struct packed {
    logic [2:0] prio;
    logic [3:0] pow;
    logic       dst_wrap;
    logic       src_wrap;
    logic       trig_burst;
    logic       trig_high;
    logic       trig_level;
    logic       hwtrig_en;
    logic       preq_en;
  } chan_cfg_t;

  localparam int unsigned CFG_W = $bits(chan_cfg_t);

  // Burst length for an exponent; zero for an unsupported exponent.
  function automatic logic [LEN_W-1:0] burst_len(input logic [3:0] pow);
    if (pow > 4'(MAX_POW)) return '0;
    return LEN_W'(1) << pow;
  endfunction

  // A transfer shape is valid when the exponent is supported and the
  // count is a nonzero whole multiple of the burst length.
  function automatic logic shape_ok(input logic [3:0] pow, input logic [31:0] cnt);
    logic [31:0] mask;
    if (pow > 4'(MAX_POW)) return 1'b0;
    mask = (32'd1 << pow) - 32'd1;
    return (cnt != 32'd0) && ((cnt & mask) == 32'd0);
  endfunction

endpackage

// File: rtl/dbs_trig_cond.sv
module dbs_trig_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_trig,
  input  logic level_mode,
  input  logic active_high,
  output logic trig_hit
);
  logic trig_act;
  logic trig_prev;
  logic trig_edge;

  assign trig_act  = active_high ? hw_trig : ~hw_trig;
  assign trig_edge = trig_act & ~trig_prev;
  assign trig_hit  = level_mode ? trig_act : trig_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_prev <= 1'b0;
    else        trig_prev <= trig_act;
  end

  // R5: an edge event never lasts two cycles while the sensing is unchanged
  p_edge_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit && !level_mode |=> !trig_hit || level_mode || !$stable(active_high));

endmodule

// File: rtl/dbs_credit.sv
module dbs_credit #(
  parameter int unsigned LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             hw_mode,
  input  logic             level_mode,
  input  logic             trig_hit,
  input  logic [LEN_W-1:0] grant_len,
  input  logic             beat_fire,
  output logic             have_credit
);
  logic [LEN_W-1:0] credit;
  logic             pending;
  logic             credit_idle;

  assign credit_idle = (credit == '0);
  assign have_credit = !credit_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit  <= '0;
      pending <= 1'b0;
    end else if (clear || !hw_mode) begin
      credit  <= '0;
      pending <= 1'b0;
    end else if (credit_idle) begin
      if (trig_hit || pending) begin
        credit  <= grant_len;
        pending <= 1'b0;
      end
    end else begin
      if (beat_fire)               credit  <= credit - LEN_W'(1);
      if (trig_hit && !level_mode) pending <= 1'b1;
    end
  end

  // R4: a beat under trigger control only completes inside an open grant
  p_fire_needs_credit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hw_mode && beat_fire |-> have_credit);

  // R4: each completed beat consumes exactly one granted beat
  p_credit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hw_mode && !clear && have_credit && beat_fire |=> credit == $past(credit) - LEN_W'(1));

endmodule

// File: rtl/dbs_addr_walk.sv
module dbs_addr_walk #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  input  logic          wrap_en,
  input  logic          burst_end,
  input  logic          beat_fire,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] base_q;
  logic          wrap_now;

  assign wrap_now = wrap_en && burst_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      base_q <= '0;
    end else if (load) begin
      addr   <= base;
      base_q <= base;
    end else if (beat_fire) begin
      addr <= wrap_now ? base_q : addr + step;
    end
  end

  // R8: a completed beat outside a wrap point moves the address by one step
  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !load && !wrap_now |=> addr == $past(addr) + $past(step));

  // R9: the last beat of a wrapping burst brings the address back to its start
  p_addr_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !load && wrap_now |=> addr == base_q);

  // R8: without a completed beat or a load the address holds
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_fire && !load |=> $stable(addr));

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dbs_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [13:0]      cfg_word,
  input  logic             start,
  input  logic [CNT_W-1:0] xfer_count,
  input  logic [AW-1:0]    src_base,
  input  logic [AW-1:0]    dst_base,
  input  logic [AW-1:0]    src_step,
  input  logic [AW-1:0]    dst_step,
  input  logic             periph_req,
  input  logic             hw_trig,
  input  logic             beat_done,
  output logic             ch_req,
  output logic [2:0]       ch_prio,
  output logic [AW-1:0]    src_addr,
  output logic [AW-1:0]    dst_addr,
  output logic             xfer_done,
  output logic             cfg_err
);
  localparam int unsigned NSIDE = 2;

  chan_cfg_t        cfg;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] grant_len;
  logic [LEN_W-1:0] bidx;
  logic [CNT_W-1:0] remaining;
  logic             active;
  logic             start_ok;
  logic             load;
  logic             burst_end;
  logic             last_beat;
  logic             beat_fire;
  logic             trig_hit;
  logic             have_credit;
  logic             gate_hw;
  logic             gate_pr;

  assign cfg       = chan_cfg_t'(cfg_word);
  assign ch_prio   = cfg.prio;
  assign len       = burst_len(cfg.pow);
  assign grant_len = cfg.trig_burst ? len : LEN_W'(1);
  assign start_ok  = shape_ok(cfg.pow, 32'(xfer_count));
  assign load      = start && start_ok;
  assign burst_end = (bidx == len - LEN_W'(1));
  assign last_beat = (remaining == CNT_W'(1));

  assign gate_hw   = !cfg.hwtrig_en || have_credit;
  assign gate_pr   = !cfg.preq_en || periph_req;
  assign ch_req    = active && gate_hw && gate_pr;
  assign beat_fire = ch_req && beat_done;

  // Transfer state: remaining count, beat index inside the burst, flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      xfer_done <= 1'b0;
      cfg_err   <= 1'b0;
      remaining <= '0;
      bidx      <= '0;
    end else if (start) begin
      active    <= start_ok;
      cfg_err   <= !start_ok;
      xfer_done <= 1'b0;
      remaining <= start_ok ? xfer_count : '0;
      bidx      <= '0;
    end else if (beat_fire) begin
      remaining <= remaining - CNT_W'(1);
      bidx      <= burst_end ? '0 : bidx + LEN_W'(1);
      if (last_beat) begin
        active    <= 1'b0;
        xfer_done <= 1'b1;
      end
    end
  end

  dbs_trig_cond i_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_trig     (hw_trig),
    .level_mode  (cfg.trig_level),
    .active_high (cfg.trig_high),
    .trig_hit    (trig_hit)
  );

  dbs_credit #(.LEN_W(LEN_W)) i_credit (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (start || !active),
    .hw_mode     (cfg.hwtrig_en),
    .level_mode  (cfg.trig_level),
    .trig_hit    (trig_hit),
    .grant_len   (grant_len),
    .beat_fire   (beat_fire),
    .have_credit (have_credit)
  );

  // Index 0 is the source side, index 1 the destination side
  logic [NSIDE-1:0][AW-1:0] side_base;
  logic [NSIDE-1:0][AW-1:0] side_step;
  logic [NSIDE-1:0][AW-1:0] side_addr;
  logic [NSIDE-1:0]         side_wrap;

  assign side_base = {dst_base, src_base};
  assign side_step = {dst_step, src_step};
  assign side_wrap = {cfg.dst_wrap, cfg.src_wrap};

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dbs_addr_walk #(.AW(AW)) i_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .base      (side_base[g]),
      .step      (side_step[g]),
      .wrap_en   (side_wrap[g]),
      .burst_end (burst_end),
      .beat_fire (beat_fire),
      .addr      (side_addr[g])
    );
  end

  assign src_addr = side_addr[0];
  assign dst_addr = side_addr[1];

  // R2: a valid start loads the full count
  p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active && !cfg_err && remaining == $past(xfer_count));

  // R2: a rejected start flags the error and raises no request
  p_bad_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !start_ok |=> cfg_err && !ch_req);

  // R10: the last beat ends the transfer and silences the request
  p_last_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && last_beat && !start |=> xfer_done && !ch_req);

endmodule

// File: tb/test_dma_burst_seq.sv
module test_dma_burst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 16;
  localparam int CNT_W = 16;
  localparam logic [AW-1:0] SB = 16'h1000;
  localparam logic [AW-1:0] DB = 16'h2000;
  localparam logic [AW-1:0] SS = 16'd4;
  localparam logic [AW-1:0] DS = 16'd1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [13:0]      cfg_word = '0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] xfer_count = '0;
  logic             periph_req = 1'b0;
  logic             hw_trig = 1'b0;
  logic             beat_done = 1'b0;
  logic             ch_req;
  logic [2:0]       ch_prio;
  logic [AW-1:0]    src_addr;
  logic [AW-1:0]    dst_addr;
  logic             xfer_done;
  logic             cfg_err;

  int nchk = 0;
  int nfail = 0;
  int nfire = 0;
  logic [AW-1:0] src_log [256];
  logic [AW-1:0] dst_log [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_burst_seq #(.AW(AW), .CNT_W(CNT_W)) i_dma_burst_seq (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .start(start),
    .xfer_count(xfer_count), .src_base(SB), .dst_base(DB),
    .src_step(SS), .dst_step(DS), .periph_req(periph_req),
    .hw_trig(hw_trig), .beat_done(beat_done), .ch_req(ch_req),
    .ch_prio(ch_prio), .src_addr(src_addr), .dst_addr(dst_addr),
    .xfer_done(xfer_done), .cfg_err(cfg_err)
  );

  // Bus-side monitor: a beat completes at the next edge when both are high
  always @(negedge clk) begin
    if (rst_n && ch_req && beat_done) begin
      src_log[nfire % 256] <= src_addr;
      dst_log[nfire % 256] <= dst_addr;
      nfire <= nfire + 1;
    end
  end

  function automatic logic [13:0] mk(input int prio, input int pow, input bit dw, input bit sw,
                                     input bit tb, input bit th, input bit tl, input bit he,
                                     input bit pe);
    return {3'(prio), 4'(pow), dw, sw, tb, th, tl, he, pe};
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] base, input logic [AW-1:0] step,
                                             input int i, input bit wrap, input int size);
    int k;
    k = wrap ? (i % size) : i;
    return base + AW'(k) * step;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic begin_run(input logic [13:0] cw, input int count, input bit idle, input bit bd);
    cfg_word = cw; xfer_count = CNT_W'(count); hw_trig = idle; beat_done = bd;
    cyc(2);
    start = 1'b1;
    cyc(1);
    start = 1'b0;
  endtask

  task automatic pulse(input bit act);
    hw_trig = act;
    cyc(1);
    hw_trig = ~act;
    cyc(1);
  endtask

  task automatic t_reset;
    chk(ch_req == 1'b0,    "R10 reset ch_req",    ch_req, 0);
    chk(xfer_done == 1'b0, "R10 reset xfer_done", xfer_done, 0);
    chk(cfg_err == 1'b0,   "R10 reset cfg_err",   cfg_err, 0);
  endtask

  task automatic t_bad_cfg;
    int b;
    b = nfire;
    begin_run(mk(0, 11, 0, 0, 0, 1, 0, 0, 0), 2048, 0, 1);
    chk(cfg_err == 1'b1, "R1 exponent 11 rejected", cfg_err, 1);
    chk(ch_req == 1'b0,  "R1 no request on bad exponent", ch_req, 0);
    begin_run(mk(0, 3, 0, 0, 0, 1, 0, 0, 0), 12, 0, 1);
    chk(cfg_err == 1'b1, "R2 count 12 with burst 8 rejected", cfg_err, 1);
    begin_run(mk(0, 0, 0, 0, 0, 1, 0, 0, 0), 0, 0, 1);
    chk(cfg_err == 1'b1, "R2 zero count rejected", cfg_err, 1);
    cyc(3);
    chk(nfire == b, "R2 no beats after rejected start", nfire - b, 0);
    chk(xfer_done == 1'b0, "R2 no done after rejected start", xfer_done, 0);
  endtask

  task automatic t_free_run;
    int b;
    b = nfire;
    begin_run(mk(5, 2, 0, 0, 0, 1, 0, 0, 0), 8, 0, 1);
    chk(cfg_err == 1'b0, "R2 valid start clears error", cfg_err, 0);
    chk(ch_req == 1'b1, "R3 request right after start", ch_req, 1);
    chk(ch_prio == 3'd5, "R11 priority field", ch_prio, 5);
    cyc(10);
    chk(nfire - b == 8, "R3 free run beat count", nfire - b, 8);
    chk(xfer_done == 1'b1, "R10 done after last beat", xfer_done, 1);
    chk(ch_req == 1'b0, "R10 no request after done", ch_req, 0);
    for (int i = 0; i < 8; i++) begin
      chk(src_log[(b + i) % 256] == exp_addr(SB, SS, i, 0, 4), "R8 source sequence",
          src_log[(b + i) % 256], exp_addr(SB, SS, i, 0, 4));
      chk(dst_log[(b + i) % 256] == exp_addr(DB, DS, i, 0, 4), "R8 destination sequence",
          dst_log[(b + i) % 256], exp_addr(DB, DS, i, 0, 4));
    end
  endtask

  task automatic t_wrap;
    int b;
    b = nfire;
    begin_run(mk(0, 2, 0, 1, 0, 1, 0, 0, 0), 8, 0, 1);
    cyc(10);
    chk(nfire - b == 8, "R9 source wrap beat count", nfire - b, 8);
    for (int i = 0; i < 8; i++) begin
      chk(src_log[(b + i) % 256] == exp_addr(SB, SS, i, 1, 4), "R9 source wraps per burst",
          src_log[(b + i) % 256], exp_addr(SB, SS, i, 1, 4));
      chk(dst_log[(b + i) % 256] == exp_addr(DB, DS, i, 0, 4), "R9 destination unaffected",
          dst_log[(b + i) % 256], exp_addr(DB, DS, i, 0, 4));
    end
    b = nfire;
    begin_run(mk(0, 1, 1, 0, 0, 1, 0, 0, 0), 4, 0, 1);
    cyc(6);
    for (int i = 0; i < 4; i++) begin
      chk(dst_log[(b + i) % 256] == exp_addr(DB, DS, i, 1, 2), "R9 destination wraps per burst",
          dst_log[(b + i) % 256], exp_addr(DB, DS, i, 1, 2));
      chk(src_log[(b + i) % 256] == exp_addr(SB, SS, i, 0, 2), "R9 source unaffected",
          src_log[(b + i) % 256], exp_addr(SB, SS, i, 0, 2));
    end
  endtask

  task automatic t_preq_gate;
    int b;
    b = nfire;
    periph_req = 1'b0;
    begin_run(mk(0, 0, 0, 0, 0, 1, 0, 0, 1), 4, 0, 1);
    cyc(5);
    chk(nfire == b, "R7 no beats without peripheral request", nfire - b, 0);
    chk(src_addr == SB, "R8 beat_done ignored without request", src_addr, SB);
    periph_req = 1'b1;
    cyc(6);
    chk(nfire - b == 4, "R7 beats once peripheral requests", nfire - b, 4);
    chk(xfer_done == 1'b1, "R7 transfer completes", xfer_done, 1);
    periph_req = 1'b0;
  endtask

  task automatic t_edge_single;
    int b;
    b = nfire;
    begin_run(mk(0, 2, 0, 0, 0, 1, 0, 1, 0), 4, 0, 1);
    cyc(3);
    chk(nfire == b && ch_req == 1'b0, "R4 no request before trigger", nfire - b, 0);
    pulse(1'b1);
    cyc(4);
    chk(nfire - b == 1, "R4 one beat per trigger", nfire - b, 1);
    chk(ch_req == 1'b0, "R4 request drops after grant", ch_req, 0);
  endtask

  task automatic t_edge_latch;
    int b;
    b = nfire;
    begin_run(mk(0, 2, 0, 0, 1, 1, 0, 1, 0), 16, 0, 0);
    pulse(1'b1);
    pulse(1'b1);
    pulse(1'b1);
    chk(ch_req == 1'b1 && nfire == b, "R4 burst granted, bus stalled", ch_req, 1);
    beat_done = 1'b1;
    cyc(20);
    chk(nfire - b == 8, "R5 extra edges fold into one grant", nfire - b, 8);
    chk(xfer_done == 1'b0, "R10 not done with beats left", xfer_done, 0);
    chk(ch_req == 1'b0, "R4 idle after grants used", ch_req, 0);
  endtask

  task automatic t_edge_falling;
    int b;
    b = nfire;
    begin_run(mk(0, 1, 0, 0, 1, 0, 0, 1, 0), 2, 1, 1);
    cyc(3);
    chk(nfire == b, "R5 idle high gives nothing with falling sense", nfire - b, 0);
    pulse(1'b0);
    cyc(4);
    chk(nfire - b == 2, "R5 falling edge grants a burst", nfire - b, 2);
    chk(xfer_done == 1'b1, "R5 burst completes transfer", xfer_done, 1);
  endtask

  task automatic t_level;
    int b;
    int mid;
    b = nfire;
    begin_run(mk(0, 0, 0, 0, 0, 0, 1, 1, 0), 64, 1, 1);
    cyc(5);
    chk(nfire == b, "R6 inactive level grants nothing", nfire - b, 0);
    hw_trig = 1'b0;
    cyc(10);
    chk(nfire - b >= 3, "R6 held level keeps granting", nfire - b, 3);
    hw_trig = 1'b1;
    cyc(2);
    mid = nfire;
    cyc(6);
    chk(nfire == mid, "R6 grants stop after level drops", nfire - mid, 0);
    chk(ch_req == 1'b0, "R6 request low after level drops", ch_req, 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_bad_cfg();
    t_free_run();
    t_wrap();
    t_preq_gate();
    t_edge_single();
    t_edge_latch();
    t_edge_falling();
    t_level();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule